// File: doc/BRIEF.md
# Power and Boot Status LED Sequencer

This block turns the power-sequencing state and boot configuration of a board controller into levels for three status LEDs: a green LED1, a red LED2 and a green LED3. A power-state code, a boot-source flag and an FPGA-configured flag select a fixed pattern for each LED. Some patterns are steady and some are blinks with fixed period and duty. Once the FPGA reports it is configured in the running state, LED1 and LED2 follow two user inputs and LED3 goes dark.

All blink timing comes from one prescaler that divides the system clock into eighth-second units, and from a 4-bit phase counter that spans a two-second frame. Each blink pattern is a decode of that phase. When the selected blink pattern changes, the prescaler and the phase restart, so the new pattern always begins with its lit phase. Outputs are registered and active-high.

Top module: `led_status_seq`

## Requirements
- R1: With pwr_state = 0 (fatal power error), the registered outputs are led1 = 0, led2 = 0, led3 = 1.
- R2: With pwr_state = 1 (input supply missing), led1 = 0, led2 = 1 steadily, led3 = 0.
- R3: With pwr_state = 2, fpga_done = 0 and boot_sd = 0 (SPI flash), led1 = 0, led3 = 1 and led2 blinks with a period of CLK_HZ/4 cycles, lit for the first half.
- R4: With pwr_state = 2, fpga_done = 0 and boot_sd = 1 (SD card), led1 = 0, led3 = 1 and led2 blinks with a period of CLK_HZ cycles, lit for the first half.
- R5: With pwr_state = 3 or 4 (power-down), led1 = 1 and led2 blinks with a period of 2*CLK_HZ cycles, lit for the first 1/8 of the period.
- R6: led3 is 0 with pwr_state = 3 (power-down, sequencing enabled) and 1 with pwr_state = 4 (power-down, sequencing disabled).
- R7: With pwr_state = 5 (reset), and with the unused codes 6 and 7, all three LEDs are 1.
- R8: With pwr_state = 2 and fpga_done = 1, led3 = 0, and led1 and led2 equal user_led1 and user_led2 one clock earlier.
- R9: When the selected blink pattern changes (between none, 4 Hz, 1 Hz and power-down), the blink restarts: the first output after the change is the lit level, and the lit phase lasts its full length.
- R10: Every output is registered: it reflects the inputs sampled at the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock of CLK_HZ hertz |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_state | input | 3 | Power state code (0 fatal, 1 supply missing, 2 running, 3 power-down sequenced, 4 power-down unsequenced, 5 to 7 reset) |
| boot_sd | input | 1 | Boot source: 0 SPI flash, 1 SD card |
| fpga_done | input | 1 | FPGA configured flag |
| user_led1 | input | 1 | User level for LED1 after configuration |
| user_led2 | input | 1 | User level for LED2 after configuration |
| led1 | output | 1 | Green LED1, active-high |
| led2 | output | 1 | Red LED2, active-high |
| led3 | output | 1 | Green LED3, active-high |

## Verification
The bench builds the block with CLK_HZ = 64, so one eighth-second unit is 8 cycles. The 4 Hz blink then lasts 16 cycles, the 1 Hz blink 64 cycles and the power-down blink 128 cycles. Every pattern, the 1/8 duty window and several restarts after a pattern change fit in a few thousand cycles. Lit-cycle counts over whole periods check the duty cycles, and a cycle-exact model checks the phase alignment after each change.

// File: rtl/led_seq_pkg.sv
`timescale 1ns/1ps
package led_seq_pkg;

  localparam int PHASE_W = 4;

  typedef enum logic [2:0] {
    PS_FATAL      = 3'd0,
    PS_NOVIN      = 3'd1,
    PS_RUN        = 3'd2,
    PS_DOWN_SEQ   = 3'd3,
    PS_DOWN_NOSEQ = 3'd4,
    PS_RESET      = 3'd5
  } pwr_code_e;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_FAST = 2'd1,
    BK_SLOW = 2'd2,
    BK_DOWN = 2'd3
  } blink_e;

  typedef struct packed {
    logic g1;
    logic r2;
    logic g3;
  } led_set_t;

  // Which blink pattern is in use for a given state.
  function automatic blink_e pick_blink(input logic [2:0] st,
                                        input logic sd,
                                        input logic done);
    blink_e m;
    m = BK_NONE;
    case (st)
      PS_RUN:        if (!done) m = sd ? BK_SLOW : BK_FAST;
      PS_DOWN_SEQ,
      PS_DOWN_NOSEQ: m = BK_DOWN;
      default:       m = BK_NONE;
    endcase
    return m;
  endfunction

  // Lit or dark for a pattern at a phase (phase unit = 1/8 s, frame = 2 s).
  function automatic logic blink_level(input blink_e m,
                                       input logic [PHASE_W-1:0] ph);
    logic lvl;
    case (m)
      BK_FAST: lvl = (ph[0] == 1'b0);
      BK_SLOW: lvl = (ph[2] == 1'b0);
      BK_DOWN: lvl = (ph[3:1] == 3'd0);
      default: lvl = 1'b0;
    endcase
    return lvl;
  endfunction

  // LED levels for a state, given the current blink level.
  function automatic led_set_t led_map(input logic [2:0] st,
                                       input logic done,
                                       input logic u1,
                                       input logic u2,
                                       input logic bl);
    led_set_t s;
    case (st)
      PS_FATAL:      s = '{g1: 1'b0, r2: 1'b0, g3: 1'b1};
      PS_NOVIN:      s = '{g1: 1'b0, r2: 1'b1, g3: 1'b0};
      PS_RUN:        s = done ? '{g1: u1, r2: u2, g3: 1'b0}
                              : '{g1: 1'b0, r2: bl, g3: 1'b1};
      PS_DOWN_SEQ:   s = '{g1: 1'b1, r2: bl, g3: 1'b0};
      PS_DOWN_NOSEQ: s = '{g1: 1'b1, r2: bl, g3: 1'b1};
      default:       s = '{g1: 1'b1, r2: 1'b1, g3: 1'b1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/led_mode_track.sv
`timescale 1ns/1ps
module led_mode_track
  import led_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  blink_e mode_in,
  output blink_e mode_q,
  output logic   restart
);

  assign restart = (mode_in != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= BK_NONE;
    else        mode_q <= mode_in;
  end

endmodule

// File: rtl/led_tick_gen.sv
`timescale 1ns/1ps
module led_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = !restart;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      assign tick = !restart && (cnt == LAST);

      // The restart edge itself counts as the first cycle of unit 0.
      always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (restart)  cnt <= CW'(1);
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + CW'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/led_phase_ctr.sv
`timescale 1ns/1ps
module led_phase_ctr #(
  parameter int PW    = 4,
  parameter int START = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  output logic [PW-1:0] phase
);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= PW'(START);
    else if (tick)    phase <= phase + PW'(1);
  end

endmodule

// File: rtl/led_status_seq.sv
`timescale 1ns/1ps
module led_status_seq
  import led_seq_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] pwr_state,
  input  logic       boot_sd,
  input  logic       fpga_done,
  input  logic       user_led1,
  input  logic       user_led2,
  output logic       led1,
  output logic       led2,
  output logic       led3
);

  localparam int UNITS_PER_SEC = 8;
  localparam int TICK_DIV      = (CLK_HZ / UNITS_PER_SEC < 1) ? 1 : CLK_HZ / UNITS_PER_SEC;
  localparam int PH_START      = (TICK_DIV <= 1) ? 1 : 0;

  blink_e               mode_now;
  blink_e               mode_q;
  logic                 restart;
  logic                 tick;
  logic [PHASE_W-1:0]   phase;
  logic [PHASE_W-1:0]   phase_eff;
  logic                 blink_bit;
  led_set_t             led_next;

  assign mode_now = pick_blink(pwr_state, boot_sd, fpga_done);

  led_mode_track u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_in (mode_now),
    .mode_q  (mode_q),
    .restart (restart)
  );

  led_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick)
  );

  led_phase_ctr #(.PW(PHASE_W), .START(PH_START)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .phase   (phase)
  );

  assign phase_eff = restart ? '0 : phase;
  assign blink_bit = blink_level(mode_now, phase_eff);
  assign led_next  = led_map(pwr_state, fpga_done, user_led1, user_led2, blink_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led1 <= 1'b0;
      led2 <= 1'b0;
      led3 <= 1'b0;
    end else begin
      led1 <= led_next.g1;
      led2 <= led_next.r2;
      led3 <= led_next.g3;
    end
  end

endmodule

// File: rtl/led_status_seq_chk.sv
`timescale 1ns/1ps
module led_status_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pwr_state,
  input logic       fpga_done,
  input logic       user_led1,
  input logic       user_led2,
  input logic       led1,
  input logic       led2,
  input logic       led3,
  input logic       restart,
  input logic       tick,
  input logic [3:0] phase
);

  a_r1_fatal_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd0) |=> (!led1 && !led2 && led3));

  a_r2_novin_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd1) |=> (!led1 && led2 && !led3));

  a_r6_down_seq_led3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3) |=> (led1 && !led3));

  a_r6_down_noseq_led3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd4) |=> (led1 && led3));

  a_r7_reset_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state >= 3'd5) |=> (led1 && led2 && led3));

  a_r8_user_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd2 && fpga_done) |=>
      (!led3 && led1 == $past(user_led1) && led2 == $past(user_led2)));

  a_r9_restart_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (pwr_state == 3'd3 || pwr_state == 3'd4)) |=> led2);

  a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase == $past(phase) + 4'd1));

  a_r5_down_dark: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_state == 3'd3 || pwr_state == 3'd4) && !restart && phase[3:1] != 3'd0)
      |=> !led2);

endmodule

bind led_status_seq led_status_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_state (pwr_state),
  .fpga_done (fpga_done),
  .user_led1 (user_led1),
  .user_led2 (user_led2),
  .led1      (led1),
  .led2      (led2),
  .led3      (led3),
  .restart   (restart),
  .tick      (tick),
  .phase     (phase)
);

// File: tb/led_status_seq_tb.sv
`timescale 1ns/1ps
module led_status_seq_tb_top;

  localparam int HZ   = 64;
  localparam int UNIT = HZ / 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pwr_state = 3'd0;
  logic       boot_sd = 1'b0;
  logic       fpga_done = 1'b0;
  logic       user_led1 = 1'b0;
  logic       user_led2 = 1'b0;
  logic       led1, led2, led3;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;

  // Reference model state
  int prev_pat = 0;
  int age = 0;
  logic e1 = 1'b0, e2 = 1'b0, e3 = 1'b0;

  always #4 clk = ~clk;

  led_status_seq #(.CLK_HZ(HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .boot_sd(boot_sd),
    .fpga_done(fpga_done), .user_led1(user_led1), .user_led2(user_led2),
    .led1(led1), .led2(led2), .led3(led3)
  );

  // 0 none, 1 fast, 2 slow, 3 power-down
  function automatic int pattern_of(input int st, input bit sd, input bit dn);
    if (st == 2 && !dn) return sd ? 2 : 1;
    if (st == 3 || st == 4) return 3;
    return 0;
  endfunction

  function automatic bit lit(input int pat, input int a);
    int u;
    u = (a / UNIT) % 16;
    if (pat == 1) return (u % 2) == 0;
    if (pat == 2) return (u % 8) < 4;
    if (pat == 3) return u < 2;
    return 0;
  endfunction

  function automatic string tag_of(input int st, input bit sd, input bit dn);
    case (st)
      0: return "R1";
      1: return "R2";
      2: return dn ? "R8" : (sd ? "R4" : "R3");
      3: return "R5/R6";
      4: return "R5/R6";
      default: return "R7";
    endcase
  endfunction

  string cur_tag = "R10";

  always @(posedge clk) begin
    int st, pat;
    bit b;
    if (!rst_n) begin
      e1 = 0; e2 = 0; e3 = 0; prev_pat = 0; age = 0; cur_tag = "R10";
    end else begin
      st  = int'(pwr_state);
      pat = pattern_of(st, boot_sd, fpga_done);
      if (pat != prev_pat) age = 0; else age++;
      prev_pat = pat;
      b = lit(pat, age);
      cur_tag = tag_of(st, boot_sd, fpga_done);
      case (st)
        0: begin e1 = 0; e2 = 0; e3 = 1; end
        1: begin e1 = 0; e2 = 1; e3 = 0; end
        2: if (fpga_done) begin e1 = user_led1; e2 = user_led2; e3 = 0; end
           else begin e1 = 0; e2 = b; e3 = 1; end
        3: begin e1 = 1; e2 = b; e3 = 0; end
        4: begin e1 = 1; e2 = b; e3 = 1; end
        default: begin e1 = 1; e2 = 1; e3 = 1; end
      endcase
    end
    started = 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !finished) begin
      check({cur_tag, " led1"}, int'(led1), int'(e1));
      check({cur_tag, " led2"}, int'(led2), int'(e2));
      check({cur_tag, " led3"}, int'(led3), int'(e3));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_state(input int st, input bit sd, input bit dn);
    @(negedge clk);
    pwr_state = 3'(st); boot_sd = sd; fpga_done = dn;
  endtask

  task automatic count_lit(input string req, input int n, input int exp);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (led2) c++;
    end
    check(req, c, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cycles(4);
    check("R10 reset led1", int'(led1), 0);
    check("R10 reset led2", int'(led2), 0);
    check("R10 reset led3", int'(led3), 0);
    rst_n = 1'b1;
    cycles(20);
    set_state(1, 0, 0); cycles(20);
    // R3 SPI blink: first output after change lit (R9), then 50% over whole periods
    set_state(2, 0, 0);
    @(negedge clk); check("R9 fast restart lit", int'(led2), 1);
    count_lit("R3 fast duty", 4 * 2 * UNIT, 4 * UNIT);
    // R4 SD blink
    set_state(2, 1, 0);
    @(negedge clk); check("R9 slow restart lit", int'(led2), 1);
    count_lit("R4 slow duty", 2 * 8 * UNIT, 8 * UNIT);
    // R8 user passthrough
    set_state(2, 1, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); user_led1 = i[0]; user_led2 = i[1];
    end
    cycles(3);
    // R5/R6 power-down, sequenced then unsequenced
    set_state(3, 0, 0);
    @(negedge clk); check("R9 down restart lit", int'(led2), 1);
    count_lit("R5 down duty seq", 2 * 16 * UNIT, 2 * 2 * UNIT);
    set_state(4, 0, 0);
    count_lit("R5 down duty noseq", 2 * 16 * UNIT, 2 * 2 * UNIT);
    // R9 mid-period change back to fast and again to down
    set_state(2, 0, 0); cycles(5);
    set_state(3, 0, 0); cycles(40);
    set_state(2, 1, 0); cycles(37);
    // R7 reset and unused codes
    set_state(5, 0, 0); cycles(10);
    set_state(6, 0, 0); cycles(10);
    set_state(7, 1, 1); cycles(10);
    set_state(0, 0, 0); cycles(10);
    // R10 reset in mid-blink clears outputs
    set_state(4, 0, 0); cycles(20);
    @(negedge clk); rst_n = 1'b0;
    cycles(2);
    check("R10 mid reset led1", int'(led1), 0);
    check("R10 mid reset led3", int'(led3), 0);
    rst_n = 1'b1;
    cycles(300);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule